// File: doc/BRIEF.md
# Trapdoor-Guarded Timing Configuration Registers

This block sits on the host side of a small byte-addressed I/O window laid out like a disk task-file port. Host reads and writes at offsets 0 to 7 normally go straight through to the task-file side. A set of eight-bit timing and control registers sits in the same offsets. Software can reach those registers only after it unlocks them with a fixed access pattern. No separate configuration space exists.

The unlock pattern is two 16-bit reads of offset 1, then an 8-bit write of 0x03 to offset 2. Once the window is open, every write lands in the configuration registers, and none reaches the task-file side. An 8-bit write of 0x83 to offset 2 closes the window again. A second facility lets the host sample the bus-clock speed class. While the window is locked, the host writes 0xFF to offset 5 and then does a 16-bit read of offset 5. When software writes the completion code 0x85 into the control register, the strap register takes over from the clock-speed pin.

Top module: `cfg_trapdoor`

## Requirements
- R1: After reset, all eight configuration bytes read 0x00, the window is closed, the override flag is 0, no read is claimed, and the clock class follows the clock-speed pin.
- R2: A 16-bit read at offset 1, another 16-bit read at offset 1, then an 8-bit write of 0x03 at offset 2 opens the window at the clock edge of that write. The completing write is not passed to the task-file side.
- R3: While locked, any access that is not the expected next step aborts the sequence. This includes an 8-bit read at offset 1, a read or write at another offset, a 16-bit write, or a wrong data byte. A later key write then does not open the window.
- R4: A 16-bit read at offset 1 that arrives when the key write is expected restarts the sequence as step one. Three reads followed by the key leave the window closed. Four reads followed by the key open it.
- R5: While open, an 8-bit write at offset N stores the data byte into byte N of cfg_regs (bits 8N+7..8N) when N is 0, 1, 3, 5 or 6. A write at offset 2, 4 or 7, or any 16-bit write, stores nothing. No write is passed through while the window is open.
- R6: While open, an 8-bit write of 0x83 at offset 2 closes the window. Any other value written at offset 2 leaves it open.
- R7: While locked, every write except the completing key write pulses tf_we in the same cycle, and the configuration bytes do not change.
- R8: While locked, an 8-bit write of 0xFF at offset 5 arms the clock readback. If the very next access is a 16-bit read at offset 5, that read is claimed (rd_own=1) and returns rd_data = {15'b0, clk_class}. Any next access clears the arm.
- R9: An open-window 8-bit write of exactly 0x85 at offset 3 sets a sticky override flag. From then on, clk_class equals bit 0 of configuration byte 5 instead of the pin.
- R10: Every read is passed through (tf_re=1), except a claimed clock readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One host access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_off | input | 3 | Offset in the I/O window |
| bus_wdata | input | 8 | Write data byte |
| clk_speed_pin | input | 1 | Hardware clock-speed class strap |
| tf_we | output | 1 | Write forwarded to the task-file side |
| tf_re | output | 1 | Read forwarded to the task-file side |
| rd_own | output | 1 | This read is answered by the block |
| rd_data | output | 16 | Data for a claimed read, else zero |
| cfg_open | output | 1 | Configuration window is open |
| cfg_regs | output | 64 | Configuration bytes, byte N at bits 8N+7..8N |
| strap_override | output | 1 | Completion code has been written |
| clk_class | output | 1 | Effective bus-clock speed class |

## Verification
The unlock tracker and the clock-readback arm both react to a locked write at offset 5. The bench provokes this by sending two reads at offset 1 and then the 0xFF write at offset 5. It expects that single write to abort the unlock sequence and arm the readback at the same time. The bench then checks that the next 16-bit read at offset 5 is claimed with the current clock class, and that a following key write leaves the window closed. A second case also falls in one cycle: the completion-code write sets the override flag and, in the same edge, switches clk_class to the strap byte. The bench judges this immediately after that edge and through a later locked readback.

// File: rtl/cfgtd_pkg.sv
// Package: shared state encoding and fixed codes for the trapdoor block.
// Assumes: byte-wide data codes; offsets are within a 3-bit window.
package cfgtd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_OPEN = 2'd3
    } lock_st_t;

    localparam logic [7:0] KEY_OPEN  = 8'h03;
    localparam logic [7:0] KEY_CLOSE = 8'h83;
    localparam logic [7:0] KEY_DONE  = 8'h85;
    localparam logic [7:0] KEY_ARM   = 8'hFF;
endpackage

// File: rtl/cfgtd_unlock_fsm.sv
// Module: tracks the unlock pattern and reports whether the window is open.
// Assumes: at most one access per cycle, qualified by acc_valid.
module cfgtd_unlock_fsm
    import cfgtd_pkg::*;
#(
    parameter int AW       = 3,
    parameter int PROBE_OF = 1,
    parameter int GATE_OF  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_wide,
    input  logic [AW-1:0] acc_off,
    input  logic [7:0]    acc_data,
    output logic          win_open,
    output logic          swallow
);
    lock_st_t st_q, st_d;
    logic probe_rd, key_wr, close_wr;

    // Decode the three access kinds that move the sequence.
    always_comb begin
        probe_rd = acc_valid && !acc_write && acc_wide && (acc_off == AW'(PROBE_OF));
        key_wr   = acc_valid && acc_write && !acc_wide && (acc_off == AW'(GATE_OF))
                   && (acc_data == KEY_OPEN);
        close_wr = acc_valid && acc_write && !acc_wide && (acc_off == AW'(GATE_OF))
                   && (acc_data == KEY_CLOSE);
    end

    // Next-state choice: the expected step advances, anything else aborts.
    always_comb begin
        st_d = st_q;
        if (acc_valid) begin
            unique case (st_q)
                ST_IDLE: st_d = probe_rd ? ST_ONE : ST_IDLE;
                ST_ONE:  st_d = probe_rd ? ST_TWO : ST_IDLE;
                ST_TWO:  st_d = key_wr ? ST_OPEN : (probe_rd ? ST_ONE : ST_IDLE);
                ST_OPEN: st_d = close_wr ? ST_IDLE : ST_OPEN;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign win_open = (st_q == ST_OPEN);
    assign swallow  = acc_valid && acc_write && (win_open || ((st_q == ST_TWO) && key_wr));

    p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(acc_valid && acc_write && !acc_wide
                                  && acc_off == AW'(GATE_OF) && acc_data == KEY_OPEN));
    p_close_by_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_open) |-> $past(acc_valid && acc_write && !acc_wide
                                  && acc_off == AW'(GATE_OF) && acc_data == KEY_CLOSE));
endmodule

// File: rtl/cfgtd_regfile.sv
// Module: configuration byte storage with a sticky completion flag.
// Assumes: wr_en is only raised for an open-window 8-bit write.
module cfgtd_regfile
    import cfgtd_pkg::*;
#(
    parameter int AW         = 3,
    parameter int VALID_MASK = 'h6B,
    parameter int CTRL_IDX   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_idx,
    input  logic [7:0]           wr_data,
    output logic [(2**AW)*8-1:0] regs_flat,
    output logic                 done_flag
);
    localparam int NREG = 2 ** AW;

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        if (((VALID_MASK >> i) & 1) != 0) begin : g_live
            logic [7:0] byte_q;
            // Store the byte when this index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)                            byte_q <= 8'h00;
                else if (wr_en && wr_idx == AW'(i))    byte_q <= wr_data;
            end
            assign regs_flat[i*8 +: 8] = byte_q;
        end else begin : g_hole
            assign regs_flat[i*8 +: 8] = 8'h00;
        end
    end

    // Sticky flag set by the completion code in the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_flag <= 1'b0;
        else if (wr_en && wr_idx == AW'(CTRL_IDX) && wr_data == KEY_DONE)
            done_flag <= 1'b1;
    end

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |=> done_flag);
endmodule

// File: rtl/cfg_trapdoor.sv
// Module: top of the trapdoor register block; routes host accesses either
// to the task-file side or to the configuration bytes, and answers the
// clock-class readback.
// Assumes: one access per cycle; outputs tf_we/tf_re/rd_* are combinational.
module cfg_trapdoor
    import cfgtd_pkg::*;
#(
    parameter int AW         = 3,
    parameter int DW         = 16,
    parameter int VALID_MASK = 'h6B,
    parameter int PROBE_OF   = 1,
    parameter int GATE_OF    = 2,
    parameter int CTRL_IDX   = 3,
    parameter int STRAP_IDX  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_wide,
    input  logic [AW-1:0]        bus_off,
    input  logic [7:0]           bus_wdata,
    input  logic                 clk_speed_pin,
    output logic                 tf_we,
    output logic                 tf_re,
    output logic                 rd_own,
    output logic [DW-1:0]        rd_data,
    output logic                 cfg_open,
    output logic [(2**AW)*8-1:0] cfg_regs,
    output logic                 strap_override,
    output logic                 clk_class
);
    logic swallow, arm_q, cfg_we, arm_set;

    cfgtd_unlock_fsm #(.AW(AW), .PROBE_OF(PROBE_OF), .GATE_OF(GATE_OF)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(bus_valid), .acc_write(bus_write), .acc_wide(bus_wide),
        .acc_off(bus_off), .acc_data(bus_wdata),
        .win_open(cfg_open), .swallow(swallow)
    );

    assign cfg_we = cfg_open && bus_valid && bus_write && !bus_wide;

    cfgtd_regfile #(.AW(AW), .VALID_MASK(VALID_MASK), .CTRL_IDX(CTRL_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(bus_off), .wr_data(bus_wdata),
        .regs_flat(cfg_regs), .done_flag(strap_override)
    );

    // Effective clock class: strap byte once overridden, else the pin.
    assign clk_class = strap_override ? cfg_regs[STRAP_IDX*8] : clk_speed_pin;

    // Arm condition: locked 8-bit write of the arm code at the strap offset.
    assign arm_set = bus_valid && bus_write && !bus_wide && !swallow
                     && (bus_off == AW'(STRAP_IDX)) && (bus_wdata == KEY_ARM);

    // Readback arm: set by the arm write, cleared by any other access.
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_q <= 1'b0;
        else if (bus_valid) arm_q <= arm_set;
    end

    // Route each access to the task-file side or claim the readback.
    always_comb begin
        rd_own  = arm_q && bus_valid && !bus_write && bus_wide && (bus_off == AW'(STRAP_IDX));
        rd_data = rd_own ? DW'(clk_class) : '0;
        tf_re   = bus_valid && !bus_write && !rd_own;
        tf_we   = bus_valid && bus_write && !swallow;
    end

    p_no_pass_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open |-> !tf_we);
    p_own_is_strap_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_own |-> (bus_valid && !bus_write && bus_wide && bus_off == AW'(STRAP_IDX)));
    p_read_routed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> (tf_re != rd_own));
endmodule

// File: tb/cfg_trapdoor_bench.sv
`timescale 1ns/1ps
module cfg_trapdoor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic        clk_speed_pin = 1'b0;
    logic        tf_we, tf_re, rd_own, cfg_open, strap_override, clk_class;
    logic [15:0] rd_data;
    logic [63:0] cfg_regs;

    int errors = 0, checks = 0;
    logic [7:0] model [8];
    logic s_we, s_re, s_own;
    logic [15:0] s_data;
    localparam logic [7:0] MASK = 8'h6B;

    always #2.5 clk = ~clk;

    cfg_trapdoor u_cfg_trapdoor (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .clk_speed_pin(clk_speed_pin), .tf_we(tf_we), .tf_re(tf_re),
        .rd_own(rd_own), .rd_data(rd_data), .cfg_open(cfg_open),
        .cfg_regs(cfg_regs), .strap_override(strap_override), .clk_class(clk_class)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive after a falling edge, sample comb outputs, cross the rising edge.
    task automatic acc(input logic w, input logic wide, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_wide = wide; bus_off = off; bus_wdata = d;
        #1;
        s_we = tf_we; s_re = tf_re; s_own = rd_own; s_data = rd_data;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic unlock();
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
    endtask

    initial begin : watchdog
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 regs", cfg_regs, 64'h0);
        chk("R1 open", cfg_open, 0);
        chk("R1 override", strap_override, 0);
        chk("R1 own", rd_own, 0);
        clk_speed_pin = 1'b1; #1;
        chk("R1 clk_class pin", clk_class, 1);

        // R7 locked writes pass through, store nothing
        for (int o = 0; o < 8; o++) begin
            acc(1, 0, 3'(o), 8'hA0 + 8'(o));
            chk("R7 tf_we", s_we, 1);
            chk("R7 regs hold", cfg_regs, 64'h0);
        end

        // R2 unlock
        acc(0, 1, 3'd1, 8'h00); chk("R10 tf_re probe", s_re, 1);
        acc(0, 1, 3'd1, 8'h00); chk("R2 still closed", cfg_open, 0);
        acc(1, 0, 3'd2, 8'h03);
        chk("R2 key swallowed", s_we, 0);
        chk("R2 open", cfg_open, 1);

        // R5 sweep of offsets while open
        for (int o = 0; o < 8; o++) begin
            acc(1, 0, 3'(o), 8'h40 + 8'(o));
            if (MASK[o]) model[o] = 8'h40 + 8'(o);
            chk("R5 no pass", s_we, 0);
            chk("R5 regs", cfg_regs, model_flat());
        end
        acc(1, 1, 3'd0, 8'hEE);
        chk("R5 wide ignored", cfg_regs, model_flat());
        acc(0, 0, 3'd0, 8'h00);
        chk("R10 read passes while open", s_re, 1);

        // R6 relock
        acc(1, 0, 3'd2, 8'h55); chk("R6 other stays open", cfg_open, 1);
        acc(1, 0, 3'd2, 8'h83); chk("R6 closed", cfg_open, 0);
        acc(1, 0, 3'd0, 8'h99);
        chk("R7 pass after relock", s_we, 1);
        chk("R7 regs after relock", cfg_regs, model_flat());

        // R3 aborting access between steps
        for (int k = 0; k < 5; k++) begin
            for (int pos = 0; pos < 2; pos++) begin
                acc(0, 1, 3'd1, 8'h00);
                if (pos == 1) acc(0, 1, 3'd1, 8'h00);
                case (k)
                    0: acc(0, 0, 3'd1, 8'h00);
                    1: acc(0, 1, 3'd0, 8'h00);
                    2: acc(1, 0, 3'd4, 8'h12);
                    3: acc(1, 1, 3'd2, 8'h03);
                    default: acc(1, 0, 3'd2, 8'h04);
                endcase
                if (pos == 0) acc(0, 1, 3'd1, 8'h00);
                acc(1, 0, 3'd2, 8'h03);
                chk("R3 abort keeps closed", cfg_open, 0);
                chk("R7 failed key passes", s_we, 1);
            end
        end

        // R4 restart on extra probe read
        for (int n = 3; n <= 4; n++) begin
            for (int j = 0; j < n; j++) acc(0, 1, 3'd1, 8'h00);
            acc(1, 0, 3'd2, 8'h03);
            chk("R4 restart", cfg_open, (n == 4));
        end
        acc(1, 0, 3'd2, 8'h83);
        chk("R6 closed again", cfg_open, 0);

        // R8 clock readback for both pin values
        for (int p = 0; p < 2; p++) begin
            clk_speed_pin = p[0];
            acc(1, 0, 3'd5, 8'hFF); chk("R8 arm write passes", s_we, 1);
            acc(0, 1, 3'd5, 8'h00);
            chk("R8 own", s_own, 1);
            chk("R8 data", s_data, {15'b0, p[0]});
            chk("R10 claimed not passed", s_re, 0);
            acc(0, 1, 3'd5, 8'h00);
            chk("R8 arm cleared", s_own, 0);
            chk("R10 passes", s_re, 1);
        end
        acc(1, 0, 3'd5, 8'hFF); acc(0, 1, 3'd0, 8'h00); acc(0, 1, 3'd5, 8'h00);
        chk("R8 cleared by other access", s_own, 0);
        acc(1, 0, 3'd5, 8'hFF); acc(0, 0, 3'd5, 8'h00);
        chk("R8 narrow not claimed", s_own, 0);
        acc(1, 0, 3'd5, 8'hFE); acc(0, 1, 3'd5, 8'h00);
        chk("R8 wrong code not armed", s_own, 0);

        // Same cycle: arm write aborts the unlock sequence and arms readback
        clk_speed_pin = 1'b1;
        acc(0, 1, 3'd1, 8'h00); acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd5, 8'hFF);
        acc(0, 1, 3'd5, 8'h00);
        chk("R8 armed during sequence", s_own, 1);
        chk("R8 data during sequence", s_data, 16'h0001);
        acc(1, 0, 3'd2, 8'h03);
        chk("R3 arm write aborted", cfg_open, 0);

        // R9 override
        clk_speed_pin = 1'b0;
        unlock();
        acc(1, 0, 3'd3, 8'h84); model[3] = 8'h84;
        chk("R9 wrong code", strap_override, 0);
        chk("R9 pin still used", clk_class, 0);
        acc(1, 0, 3'd3, 8'h85); model[3] = 8'h85;
        chk("R9 override set", strap_override, 1);
        chk("R9 strap bit used", clk_class, 1);
        acc(1, 0, 3'd5, 8'h00); model[5] = 8'h00;
        chk("R9 strap cleared", clk_class, 0);
        acc(1, 0, 3'd3, 8'h00); model[3] = 8'h00;
        chk("R9 sticky", strap_override, 1);
        chk("R5 regs final", cfg_regs, model_flat());
        acc(1, 0, 3'd2, 8'h83);
        clk_speed_pin = 1'b1;
        acc(1, 0, 3'd5, 8'hFF); acc(0, 1, 3'd5, 8'h00);
        chk("R9 readback uses strap", s_data, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule